// File: doc/BRIEF.md
# Serial Divider Programming Interface

This block is the load port that sets the divide ratios of a frequency synthesizer over three wires: a serial clock, a serial data line and a commit strobe. Bits are shifted in most significant first on rising edges of the serial clock. The last bit of each word is a steering bit. It decides which of two holding registers the word is meant for: the 14-bit reference divide value, or the combined word that holds a 10-bit main divide value and a 7-bit swallow value. Pulsing the strobe high copies the shifted word into the register the steering bit names. Both holding registers drive the counter logic directly.

Both word lengths use the same shift path and the same strobe. The payload is always read from the bits just ahead of the steering bit, so any bits sent before the payload simply fall off the far end. All three serial inputs are asynchronous to the system clock. Each passes through a two-flop synchroniser before it is used.

Top module: `serdiv_load_port`

## Requirements
- R1: After reset, ref_div, swallow and main_div are all zero.
- R2: A word that ends with a steering bit of 1 loads ref_div when the strobe is pulsed. ref_div takes the 14 bits sent just before the steering bit, and the first of those bits becomes ref_div[13].
- R3: A word that ends with a steering bit of 0 loads the swallow and main registers when the strobe is pulsed. The 17 bits ahead of the steering bit are read in send order: the first 10 form main_div, most significant first, and the next 7 form swallow, most significant first.
- R4: While the strobe stays low, any amount of shifting leaves all three outputs unchanged.
- R5: A load into one holding register leaves the other holding register unchanged.
- R6: Bits sent before the payload have no effect. Only the last 14 or 17 bits ahead of the steering bit reach the outputs.
- R7: Holding the strobe high for several cycles gives the same result as a short pulse, and repeating the strobe with no new shifting leaves the outputs unchanged.
- R8: Only a rising edge of the serial clock shifts a bit. A falling edge, or a change on the data line while the serial clock does not rise, does not change the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, sampled on the synchronised rising edge of ser_clk |
| ser_en | input | 1 | Commit strobe, active high, asynchronous |
| ref_div | output | 14 | Reference divide value |
| swallow | output | 7 | Swallow (A) count |
| main_div | output | 10 | Main (N) divide value |

## Verification
The assertions assume that each level on ser_clk, ser_data and ser_en lasts long enough to pass through its synchroniser. They also assume that ser_data is stable around each synchronised rising edge of ser_clk, so that the data bit and the clock edge emerge from their synchronisers together. The stimulus meets this by holding every level for four system clocks, and by changing data only while the serial clock is low. The strobe is raised only after the whole word and its steering bit have been shifted in.

// File: rtl/serdiv_load_port.sv
module serdiv_load_port #(
  parameter int REF_W = 14,
  parameter int A_W = 7,
  parameter int N_W = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_data,
  input  logic             ser_en,
  output logic [REF_W-1:0] ref_div,
  output logic [A_W-1:0]   swallow,
  output logic [N_W-1:0]   main_div
);
  localparam int AN_W = A_W + N_W;
  localparam int WORD_W = (AN_W > REF_W) ? AN_W : REF_W;
  localparam int SR_W = WORD_W + 1;

  logic [SYNC_STAGES-1:0] clk_q, dat_q, en_q;
  logic sclk_d;
  logic [SR_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q <= '0;
      dat_q <= '0;
      en_q  <= '0;
      sclk_d <= 1'b0;
    end else begin
      clk_q <= {clk_q[SYNC_STAGES-2:0], ser_clk};
      dat_q <= {dat_q[SYNC_STAGES-2:0], ser_data};
      en_q  <= {en_q[SYNC_STAGES-2:0], ser_en};
      sclk_d <= clk_q[SYNC_STAGES-1];
    end
  end

  wire sclk_s = clk_q[SYNC_STAGES-1];
  wire dat_s  = dat_q[SYNC_STAGES-1];
  wire en_s   = en_q[SYNC_STAGES-1];
  wire sclk_rise = sclk_s & ~sclk_d;
  wire ctl = sr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else if (sclk_rise) sr <= {sr[SR_W-2:0], dat_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_div  <= '0;
      swallow  <= '0;
      main_div <= '0;
    end else if (en_s) begin
      if (ctl) ref_div <= sr[REF_W:1];
      else {main_div, swallow} <= sr[AN_W:1];
    end
  end
endmodule

module serdiv_load_port_chk #(
  parameter int REF_W = 14,
  parameter int A_W = 7,
  parameter int N_W = 10,
  parameter int SR_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sclk_s,
  input logic             sclk_d,
  input logic             en_s,
  input logic [SR_W-1:0]  sr,
  input logic [REF_W-1:0] ref_div,
  input logic [A_W-1:0]   swallow,
  input logic [N_W-1:0]   main_div
);
  a_r4_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> ($stable(ref_div) && $stable(swallow) && $stable(main_div)));

  a_r5_ref_load_spares_an: assert property (@(posedge clk) disable iff (!rst_n)
    (en_s && sr[0]) |=> ($stable(swallow) && $stable(main_div)));

  a_r5_an_load_spares_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (en_s && !sr[0]) |=> $stable(ref_div));

  a_r2_ref_change_needs_steer: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_div) |-> ($past(en_s) && $past(sr[0])));

  a_r3_an_change_needs_steer: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(swallow) || !$stable(main_div)) |-> ($past(en_s) && !$past(sr[0])));

  a_r8_shift_only_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_s && !sclk_d) |=> $stable(sr));
endmodule

bind serdiv_load_port serdiv_load_port_chk #(
  .REF_W(REF_W), .A_W(A_W), .N_W(N_W), .SR_W(SR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .sclk_d(sclk_d), .en_s(en_s),
  .sr(sr), .ref_div(ref_div), .swallow(swallow), .main_div(main_div)
);

// File: tb/serdiv_load_port_bench.sv
module serdiv_load_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_en = 1'b0;
  logic [13:0] ref_div;
  logic [6:0]  swallow;
  logic [9:0]  main_div;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  serdiv_load_port u_serdiv_load_port (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_en(ser_en), .ref_div(ref_div), .swallow(swallow), .main_div(main_div)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    ser_data = b; wait_cyc(4);
    ser_clk = 1'b1; wait_cyc(4);
    ser_clk = 1'b0; wait_cyc(4);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic strobe(input int n);
    ser_en = 1'b1; wait_cyc(n + 3);
    ser_en = 1'b0; wait_cyc(5);
  endtask

  task automatic t_reset;
    check("R1 ref_div", ref_div, 0);
    check("R1 swallow", swallow, 0);
    check("R1 main_div", main_div, 0);
  endtask

  task automatic t_ref_load;
    send_bits(32'h2A5B, 14); send_bit(1'b1); strobe(1);
    check("R2 ref_div", ref_div, 'h2A5B);
    check("R5 swallow after ref load", swallow, 0);
    check("R5 main_div after ref load", main_div, 0);
    send_bits(32'h3FFF, 14); send_bit(1'b1); strobe(1);
    check("R2 ref_div all ones", ref_div, 'h3FFF);
    send_bits(32'h0000, 14); send_bit(1'b1); strobe(1);
    check("R2 ref_div zero", ref_div, 0);
    send_bits(32'h2A5B, 14); send_bit(1'b1); strobe(1);
  endtask

  task automatic t_an_load;
    send_bits({10'h2C7, 7'h55}, 17); send_bit(1'b0); strobe(1);
    check("R3 main_div", main_div, 'h2C7);
    check("R3 swallow", swallow, 'h55);
    check("R5 ref_div after AN load", ref_div, 'h2A5B);
  endtask

  task automatic t_no_strobe;
    send_bits(32'h1111, 14); send_bit(1'b1);
    send_bits({10'h001, 7'h7F}, 17); send_bit(1'b0);
    check("R4 ref_div held", ref_div, 'h2A5B);
    check("R4 main_div held", main_div, 'h2C7);
    check("R4 swallow held", swallow, 'h55);
    strobe(1);
    check("R3 main_div after late strobe", main_div, 'h001);
    check("R3 swallow after late strobe", swallow, 'h7F);
  endtask

  task automatic t_leading_bits;
    send_bits(32'h2D, 6); send_bits(32'h0123, 14); send_bit(1'b1); strobe(1);
    check("R6 ref_div with leading bits", ref_div, 'h0123);
    send_bits(32'h3FFF, 14); send_bits({10'h155, 7'h2A}, 17); send_bit(1'b0); strobe(1);
    check("R6 main_div with leading bits", main_div, 'h155);
    check("R6 swallow with leading bits", swallow, 'h2A);
  endtask

  task automatic t_long_strobe;
    send_bits({10'h3FF, 7'h00}, 17); send_bit(1'b0); strobe(10);
    check("R7 main_div long strobe", main_div, 'h3FF);
    check("R7 swallow long strobe", swallow, 0);
    strobe(3);
    check("R7 main_div repeat strobe", main_div, 'h3FF);
    check("R7 ref_div untouched", ref_div, 'h0123);
  endtask

  task automatic t_no_clock_toggle;
    send_bits(32'h1ABC, 14);
    for (int i = 0; i < 5; i++) begin ser_data = ~ser_data; wait_cyc(4); end
    send_bit(1'b1);
    for (int i = 0; i < 5; i++) begin ser_data = ~ser_data; wait_cyc(4); end
    strobe(1);
    check("R8 ref_div after data toggles", ref_div, 'h1ABC);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    wait_cyc(5);
    t_reset;
    rst_n = 1'b1;
    wait_cyc(5);
    t_reset;
    t_ref_load;
    t_an_load;
    t_no_strobe;
    t_leading_bits;
    t_long_strobe;
    t_no_clock_toggle;
    finish_run;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run;
  end
endmodule